// File: doc/BRIEF.md
# Receive Byte-to-Word Packer

This block sits behind a link decoder on the receive side of a byte-serial network port. It takes a stream of bytes, each one marked when it ends a message, and packs them into 32-bit words for a host. The first byte of a word lands in the most significant byte lane. Every word carries a tail flag and a 2-bit padding count. Only the word that closes a message can be short. The final byte of a message can optionally be xored with a CRC-8 of the bytes before it.

Finished words wait in a small word queue. The host reads them through a ready/enable handshake and can watch an active-low almost-empty flag. If the queue stays full while the decoder has a byte waiting, a cycle counter runs. When it reaches its limit, the block raises a one-cycle blocked pulse. It then discards the rest of the stalled message, up to and including its end marker, so that the link can keep moving.

Top module: `rxp_word_packer`

## Requirements
- R1: Within a word, the first byte accepted goes to `rx_data[31:24]`, the second to `[23:16]`, the third to `[15:8]` and the fourth to `[7:0]`.
- R2: A word with `rx_tail`=0 always holds four message bytes and `rx_pad`=0. No other padding value ever appears with `rx_tail`=0.
- R3: The word that holds a message's last byte has `rx_tail`=1 and `rx_pad`=N. It holds 4−N valid bytes at the top end, and the last of them is the final byte of the message. The low N byte lanes carry no meaning.
- R4: `rx_rdy`=1 means the word on `rx_data`/`rx_tail`/`rx_pad` is valid. It leaves only on a rising edge where both `rx_rdy` and `rx_en` are high. While `rx_en` is low, the word stays unchanged.
- R5: `rx_ae_n` is high when 4 or more words are queued, and low otherwise.
- R6: `in_ready` is low when the queue holds DEPTH words and no discard is in progress. A byte is taken only on an edge where both `in_valid` and `in_ready` are high. No word is lost or duplicated.
- R7: When `crc_en`=1, the final byte of each message is stored xored with the CRC-8 of the message's earlier bytes. The CRC uses polynomial x^8+x^2+x+1 (0x07), starts at 0x00, takes bits MSB first and has no final xor. It restarts for every message. When `crc_en`=0, bytes are stored unchanged.
- R8: After TIMEOUT_CYC consecutive edges on which the queue is full and `in_valid` is high, `rx_blocked` is high for exactly one cycle.
- R9: From the cycle `rx_blocked` rises, `in_ready` is high. Every byte of the stalled message, its partial word included, is discarded up to and including the byte marked `in_last`. The next message is packed normally.
- R10: After reset, `rx_rdy`=0, `rx_ae_n`=0, `rx_blocked`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crc_en | input | 1 | Enable CRC-8 xor on the last byte; change only while idle |
| in_valid | input | 1 | Decoder presents a byte |
| in_byte | input | 8 | Received byte |
| in_last | input | 1 | This byte ends the message |
| in_ready | output | 1 | Block takes the byte on this edge |
| rx_data | output | 32 | Head word, first byte in the top lane |
| rx_tail | output | 1 | Head word ends a message |
| rx_pad | output | 2 | Unused low byte lanes in a tail word |
| rx_rdy | output | 1 | A word is available |
| rx_en | input | 1 | Host takes the word when `rx_rdy` is high |
| rx_ae_n | output | 1 | Low when fewer than 4 words are queued |
| rx_blocked | output | 1 | One-cycle pulse on a stall timeout |

## Verification
The hardest state to reach is the timeout with a message half received. The queue must be full of complete messages, the host must stay idle, and a new message's first byte must be held on the input. The bench gets there by sending eight single-byte messages with `rx_enable` low, then holding one byte of a fresh message. It counts edges until the pulse appears, and it checks that the pulse lasts one cycle. It then sends the message's end marker and drains the queue, expecting only the eight earlier words. Finally it sends a new message and expects that message to arrive intact.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

  typedef struct packed {
    logic [31:0] data;
    logic        tail;
    logic [1:0]  pad;
  } rxp_word_t;

  // CRC-8, polynomial 0x07, MSB first, one byte per call
  function automatic logic [7:0] rxp_crc8_step(input logic [7:0] crc_in,
                                                input logic [7:0] b);
    logic [7:0] c;
    c = crc_in ^ b;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/rxp_assembler.sv
module rxp_assembler
  import rxp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       crc_en,
  input  logic       accept,
  input  logic       discard,
  input  logic [7:0] in_byte,
  input  logic       in_last,
  output logic       push,
  output rxp_word_t  word
);

  logic [23:0] acc;
  logic [1:0]  lane;
  logic [7:0]  crc;
  logic [7:0]  store_byte;

  assign store_byte = (in_last && crc_en) ? (in_byte ^ crc) : in_byte;
  assign push       = accept && !discard && (in_last || lane == 2'd3);

  always_comb begin
    word.data = {acc, 8'h00};
    word.data[31 - 8*int'(lane) -: 8] = store_byte;
    word.tail = in_last;
    word.pad  = in_last ? (2'd3 - lane) : 2'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      lane <= '0;
      crc  <= '0;
    end else if (accept) begin
      if (discard || in_last) begin
        acc  <= '0;
        lane <= '0;
        crc  <= '0;
      end else begin
        crc <= rxp_crc8_step(crc, in_byte);
        if (lane == 2'd3) begin
          acc  <= '0;
          lane <= '0;
        end else begin
          acc[23 - 8*int'(lane) -: 8] <= in_byte;
          lane <= lane + 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/rxp_word_fifo.sv
module rxp_word_fifo #(
  parameter int DEPTH    = 8,
  parameter int WIDTH    = 35,
  parameter int AE_LEVEL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic             ae_n
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count, count_nx;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_comb begin
    count_nx = count;
    if (do_push && !do_pop) count_nx = count + 1'b1;
    if (do_pop && !do_push) count_nx = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ae_n   <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count_nx;
      ae_n  <= (count_nx >= CW'(AE_LEVEL));
    end
  end

endmodule

// File: rtl/rxp_stall_timer.sv
module rxp_stall_timer #(
  parameter int TIMEOUT_CYC = 4_166_667
) (
  input  logic clk,
  input  logic rst,
  input  logic stalled,
  input  logic end_msg,
  output logic blocked,
  output logic discard
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [TW-1:0] waited;

  always_ff @(posedge clk) begin
    if (rst) begin
      waited  <= '0;
      blocked <= 1'b0;
      discard <= 1'b0;
    end else begin
      blocked <= 1'b0;
      if (discard) begin
        waited <= '0;
        if (end_msg) discard <= 1'b0;
      end else if (stalled) begin
        if (waited == TW'(TIMEOUT_CYC - 1)) begin
          waited  <= '0;
          blocked <= 1'b1;
          discard <= 1'b1;
        end else begin
          waited <= waited + 1'b1;
        end
      end else begin
        waited <= '0;
      end
    end
  end

endmodule

// File: rtl/rxp_word_packer.sv
module rxp_word_packer
  import rxp_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int AE_LEVEL    = 4,
  parameter int TIMEOUT_CYC = 4_166_667
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        crc_en,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  input  logic        in_last,
  output logic        in_ready,
  output logic [31:0] rx_data,
  output logic        rx_tail,
  output logic [1:0]  rx_pad,
  output logic        rx_rdy,
  input  logic        rx_en,
  output logic        rx_ae_n,
  output logic        rx_blocked
);

  localparam int WW = $bits(rxp_word_t);

  logic      accept, push, discard, q_empty, q_full;
  rxp_word_t new_word, head;

  assign in_ready = discard || !q_full;
  assign accept   = in_valid && in_ready;
  assign rx_rdy   = !q_empty;
  assign rx_data  = head.data;
  assign rx_tail  = head.tail;
  assign rx_pad   = head.pad;

  rxp_assembler u_asm (
    .clk(clk), .rst(rst), .crc_en(crc_en), .accept(accept),
    .discard(discard), .in_byte(in_byte), .in_last(in_last),
    .push(push), .word(new_word)
  );

  rxp_word_fifo #(.DEPTH(DEPTH), .WIDTH(WW), .AE_LEVEL(AE_LEVEL)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(new_word),
    .pop(rx_en), .dout(head), .empty(q_empty), .full(q_full), .ae_n(rx_ae_n)
  );

  rxp_stall_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst(rst), .stalled(in_valid && q_full),
    .end_msg(accept && in_last), .blocked(rx_blocked), .discard(discard)
  );

endmodule

// File: rtl/rxp_word_packer_chk.sv
module rxp_word_packer_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_ready,
  input logic [31:0] rx_data,
  input logic        rx_tail,
  input logic [1:0]  rx_pad,
  input logic        rx_rdy,
  input logic        rx_en,
  input logic        rx_ae_n,
  input logic        rx_blocked
);

  p_pad_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_rdy && !rx_tail) |-> (rx_pad == 2'd0));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_rdy && !rx_en) |=> (rx_rdy && $stable(rx_data) && $stable(rx_tail) && $stable(rx_pad)));

  p_ae_has_word_r5: assert property (@(posedge clk) disable iff (rst)
    rx_ae_n |-> rx_rdy);

  p_stall_full_r6: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> rx_rdy);

  p_pulse_once_r8: assert property (@(posedge clk) disable iff (rst)
    rx_blocked |=> !rx_blocked);

  p_drain_open_r9: assert property (@(posedge clk) disable iff (rst)
    rx_blocked |-> in_ready);

endmodule

bind rxp_word_packer rxp_word_packer_chk u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .rx_data(rx_data),
  .rx_tail(rx_tail), .rx_pad(rx_pad), .rx_rdy(rx_rdy), .rx_en(rx_en),
  .rx_ae_n(rx_ae_n), .rx_blocked(rx_blocked)
);

// File: tb/tb_rxp_word_packer.sv
module tb_rxp_word_packer;
  import rxp_pkg::*;

  localparam int TO = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, crc_en, in_valid, in_last, in_ready, rx_tail, rx_rdy, rx_en, rx_ae_n, rx_blocked;
  logic [7:0]  in_byte;
  logic [31:0] rx_data;
  logic [1:0]  rx_pad;

  rxp_word_packer #(.DEPTH(8), .AE_LEVEL(4), .TIMEOUT_CYC(TO)) dut (
    .clk(clk), .rst(rst), .crc_en(crc_en), .in_valid(in_valid), .in_byte(in_byte),
    .in_last(in_last), .in_ready(in_ready), .rx_data(rx_data), .rx_tail(rx_tail),
    .rx_pad(rx_pad), .rx_rdy(rx_rdy), .rx_en(rx_en), .rx_ae_n(rx_ae_n),
    .rx_blocked(rx_blocked)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0] msg [16];
  int mlen;
  rxp_word_t exp_q [$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c;
    for (int j = 7; j >= 0; j--) begin
      logic fb = r[7] ^ b[j];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic model_msg(input bit crc_on);
    rxp_word_t w = '0;
    logic [7:0] c = 8'h00;
    for (int i = 0; i < mlen; i++) begin
      logic [7:0] b = msg[i];
      bit last = (i == mlen - 1);
      int k = i % 4;
      if (last && crc_on) b = b ^ c;
      else c = ref_crc(c, b);
      w.data[31 - 8*k -: 8] = b;
      if (k == 3 || last) begin
        w.tail = last;
        w.pad  = last ? 2'(3 - k) : 2'd0;
        exp_q.push_back(w);
        w = '0;
      end
    end
  endtask

  task automatic send_msg(input bit crc_on);
    crc_en = crc_on;
    model_msg(crc_on);
    for (int i = 0; i < mlen; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_byte = msg[i]; in_last = (i == mlen - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while (exp_q.size() > 0 && guard < 200) begin
      @(negedge clk);
      guard++;
      if (rx_rdy) begin
        rxp_word_t e = exp_q.pop_front();
        logic [31:0] m = 32'hFFFF_FFFF << (8 * int'(e.pad));
        chk(rx_tail == e.tail, {req, " tail"}, 64'(rx_tail), 64'(e.tail));
        chk(rx_pad == e.pad, {req, " pad"}, 64'(rx_pad), 64'(e.pad));
        chk((rx_data & m) == (e.data & m), {req, " data"}, 64'(rx_data & m), 64'(e.data & m));
        rx_en = 1'b1;
      end else rx_en = 1'b0;
    end
    @(negedge clk);
    rx_en = 1'b0;
    chk(exp_q.size() == 0, {req, " all words seen"}, 64'(exp_q.size()), 64'd0);
    chk(!rx_rdy, {req, " no extra word"}, 64'(rx_rdy), 64'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1; crc_en = 1'b0; in_valid = 1'b0; in_byte = '0; in_last = 1'b0; rx_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!rx_rdy && !rx_ae_n && !rx_blocked && in_ready, "R10 reset state",
        64'({rx_rdy, rx_ae_n, rx_blocked, in_ready}), 64'b0001);
  endtask

  task automatic t_packing();
    // R1 byte order, R3 full tail word
    msg[0] = 8'hDE; msg[1] = 8'hAD; msg[2] = 8'hBE; msg[3] = 8'hEF; mlen = 4;
    send_msg(1'b0); drain("R1 four-byte message");
    // R2 full non-tail word then R3 tail with pad 2
    for (int i = 0; i < 6; i++) msg[i] = 8'(8'h10 + i);
    mlen = 6; send_msg(1'b0); drain("R2 six-byte message");
    msg[0] = 8'hA5; mlen = 1; send_msg(1'b0); drain("R3 one-byte pad 3");
    for (int i = 0; i < 7; i++) msg[i] = 8'(8'hC0 ^ (i * 8'h13));
    mlen = 7; send_msg(1'b0); drain("R3 seven-byte pad 1");
  endtask

  task automatic t_crc();
    msg[0] = 8'h31; msg[1] = 8'h32; msg[2] = 8'h33; mlen = 3; send_msg(1'b1);
    for (int i = 0; i < 5; i++) msg[i] = 8'(8'h5A + 8'h21 * i);
    mlen = 5; send_msg(1'b1);
    drain("R7 crc on, restarts per message");
    crc_en = 1'b0;
  endtask

  task automatic t_level_hold();
    logic [31:0] d0;
    for (int n = 0; n < 3; n++) begin msg[0] = 8'(8'h70 + n); mlen = 1; send_msg(1'b0); end
    chk(!rx_ae_n && rx_rdy, "R5 three words ae_n low", 64'({rx_ae_n, rx_rdy}), 64'b01);
    msg[0] = 8'h73; mlen = 1; send_msg(1'b0);
    chk(rx_ae_n, "R5 four words ae_n high", 64'(rx_ae_n), 64'd1);
    d0 = rx_data;
    repeat (3) @(negedge clk);
    chk(rx_rdy && rx_data == d0, "R4 word held without enable", 64'(rx_data), 64'(d0));
    rx_en = 1'b1; @(negedge clk); rx_en = 1'b0;
    void'(exp_q.pop_front());
    chk(!rx_ae_n, "R5 three words after pop", 64'(rx_ae_n), 64'd0);
    chk(rx_data[31:24] == 8'h71, "R4 next word after one pop", 64'(rx_data[31:24]), 64'h71);
    drain("R4 remaining words");
  endtask

  task automatic t_block();
    int first_k = -1, n_high = 0;
    for (int n = 0; n < 8; n++) begin msg[0] = 8'(8'h80 + n); mlen = 1; send_msg(1'b0); end
    chk(!in_ready, "R6 ready low when full", 64'(in_ready), 64'd0);
    @(negedge clk);
    in_valid = 1'b1; in_byte = 8'h55; in_last = 1'b0;
    for (int k = 1; k <= TO + 3; k++) begin
      @(negedge clk);
      if (rx_blocked) begin
        n_high++;
        if (first_k < 0) begin
          first_k = k;
          chk(in_ready, "R9 ready during discard", 64'(in_ready), 64'd1);
        end
      end
    end
    chk(first_k == TO, "R8 pulse timing", 64'(first_k), 64'(TO));
    chk(n_high == 1, "R8 pulse width", 64'(n_high), 64'd1);
    in_byte = 8'h66; in_last = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    drain("R9 only earlier words kept");
    msg[0] = 8'h01; msg[1] = 8'h02; msg[2] = 8'h03; msg[3] = 8'h04; msg[4] = 8'h05; mlen = 5;
    send_msg(1'b0); drain("R9 next message intact");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_packing();
        t_crc();
        t_level_hold();
        t_block();
      end
      begin
        repeat (50000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule